// File: doc/BRIEF.md
# Port Event and Status Register Bank

This block keeps the per-port completion flags, the result codes and the latched faults for a four-port power controller. It also holds the port-reset and software-reset controls. Each port controller sends it one-cycle pulses when detection or classification finishes, together with a 3-bit result code. Fault sources reach it as abstract one-cycle pulses. A simple strobe bus reads and writes it. The bus has a read strobe, a write strobe, a 3-bit address and a byte of data.

The completion flags can be read at two addresses. One leaves them untouched. The other clears every flag it returns. Each port has a status byte that holds its latest detection and classification codes. Flags and codes of one port are cleared when software resets that port or when the port powers down. The active-low interrupt output stays low while any fault is latched. Software clears faults by writing ones to the fault register. A hardware reset or a software reset also clears them.

Top module: `esr_bank`

## Requirements
- R1: The event byte holds detection-complete flags for ports 0..3 in bits [3:0] and classification-complete flags for ports 0..3 in bits [7:4]. A flag is set one cycle after its completion pulse.
- R2: Read data is registered and valid in the cycle after the read strobe. A read of address 0 returns the event byte and leaves the flags unchanged.
- R3: A read of address 1 returns the event byte and clears all flags at the same clock edge.
- R4: The status byte of port n is at address 2+n. Bits [2:0] hold the last detection code and bits [6:4] hold the last class code. Bits 3 and 7 read 0. Each field loads on its port's completion pulse.
- R5: A completion pulse in the same cycle as any clear of that flag (clear-on-read, port reset or power-down) leaves the flag set and loads the new code.
- R6: Writing 1 to bit n (n = 0..3) of address 7 drives port_off_o[n] high for the next cycle. At the end of that cycle it clears only port n's two flags and its status byte. Other ports and the fault latch are unaffected.
- R7: A pulse on pwr_dn_i[n] clears port n's two flags and its status byte at the next edge.
- R8: Writing 1 to bit 4 of address 7 returns every register to 0 one cycle later. This includes the flags, the status bytes and the fault latch.
- R9: A pulse on fault_i[n] sets bit n of the fault register at address 6. int_n_o is low while any fault bit is set. Writing 1 to a bit of address 6 clears it. A hardware reset clears all fault bits.
- R10: The controls at address 7 self-clear after one cycle and always read back as 0. Unmapped bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high hardware reset |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| det_done_i | input | 4 | Detection-complete pulses, one per port |
| det_code_i | input | 12 | Detection codes, port n at [3n+2:3n] |
| cls_done_i | input | 4 | Classification-complete pulses |
| cls_code_i | input | 12 | Class codes, port n at [3n+2:3n] |
| pwr_dn_i | input | 4 | Port power-down pulses |
| fault_i | input | 4 | Fault pulses |
| port_off_o | output | 4 | One-cycle power-removal command per port |
| int_n_o | output | 1 | Active-low interrupt, low while a fault is latched |

## Verification
The assertions assume that completion, power-down and fault inputs are single-cycle pulses and that codes are stable while their pulse is high. They also assume that read and write strobes are never raised in the same cycle. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It never overlaps a read with a write. Collisions between a completion pulse and a clear are therefore made only on purpose.

// File: rtl/esr_pkg.sv
package esr_pkg;
    localparam int NPORT  = 4;
    localparam int CODE_W = 3;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_EVT     = 3'd0;
    localparam logic [ADDR_W-1:0] A_EVT_COR = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT0   = 3'd2;
    localparam logic [ADDR_W-1:0] A_FAULT   = 3'd6;
    localparam logic [ADDR_W-1:0] A_CTL     = 3'd7;
    localparam int               SRST_BIT  = 4;

    typedef struct packed {
        logic [CODE_W-1:0] cls;
        logic [CODE_W-1:0] det;
    } port_res_t;

    function automatic logic [DATA_W-1:0] fmt_status(port_res_t r);
        return {1'b0, r.cls, 1'b0, r.det};
    endfunction
endpackage

// File: rtl/esr_flag_bits.sv
module esr_flag_bits #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= (q & ~clr_i) | set_i;
    end

    assign q_o = q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R1 / R9: a set pulse always lands, even against a clear (R5)
        p_set_wins_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            set_i[i] |=> q_o[i]);
        // R3: a clear without a set empties the bit
        p_clear_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    end
endmodule

// File: rtl/esr_port_status.sv
module esr_port_status
    import esr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              det_done_i,
    input  logic [CODE_W-1:0] det_code_i,
    input  logic              cls_done_i,
    input  logic [CODE_W-1:0] cls_code_i,
    output port_res_t         res_o
);
    port_res_t res;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res <= '0;
        end else begin
            if (det_done_i)  res.det <= det_code_i;
            else if (clr_i)  res.det <= '0;
            if (cls_done_i)  res.cls <= cls_code_i;
            else if (clr_i)  res.cls <= '0;
        end
    end

    assign res_o = res;

    // R4: a completion pulse loads the code
    p_det_load_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        det_done_i |=> res_o.det == $past(det_code_i));
    p_cls_load_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        cls_done_i |=> res_o.cls == $past(cls_code_i));
    // R7: a clear without a load zeroes the field
    p_det_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && !det_done_i) |=> res_o.det == '0);
endmodule

// File: rtl/esr_bank.sv
module esr_bank
    import esr_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    rd_en_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    input  logic [NPORT-1:0]        det_done_i,
    input  logic [NPORT*CODE_W-1:0] det_code_i,
    input  logic [NPORT-1:0]        cls_done_i,
    input  logic [NPORT*CODE_W-1:0] cls_code_i,
    input  logic [NPORT-1:0]        pwr_dn_i,
    input  logic [NPORT-1:0]        fault_i,
    output logic [NPORT-1:0]        port_off_o,
    output logic                    int_n_o
);
    localparam int EVT_W = 2 * NPORT;

    logic              srst_q;
    logic [NPORT-1:0]  port_rst_q;
    logic              rst_all;
    logic              wr_ctl, wr_flt, rd_cor;
    logic [NPORT-1:0]  port_clr;
    logic [EVT_W-1:0]  evt_q, evt_clr;
    logic [NPORT-1:0]  flt_q, flt_clr;
    port_res_t         res [NPORT];
    logic [DATA_W-1:0] rmux, rdata_q;

    assign rst_all = rst_i | srst_q;
    assign wr_ctl  = wr_en_i && (addr_i == A_CTL);
    assign wr_flt  = wr_en_i && (addr_i == A_FAULT);
    assign rd_cor  = rd_en_i && (addr_i == A_EVT_COR);

    // Self-clearing controls: high only in the cycle after the write
    always_ff @(posedge clk_i) begin
        if (rst_i) srst_q <= 1'b0;
        else       srst_q <= wr_ctl && wdata_i[SRST_BIT] && !srst_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_all)     port_rst_q <= '0;
        else if (wr_ctl) port_rst_q <= wdata_i[NPORT-1:0];
        else             port_rst_q <= '0;
    end

    assign port_off_o = port_rst_q;
    assign port_clr   = port_rst_q | pwr_dn_i;
    assign evt_clr    = {EVT_W{rd_cor}} | {port_clr, port_clr};
    assign flt_clr    = wr_flt ? wdata_i[NPORT-1:0] : '0;

    esr_flag_bits #(.W(EVT_W)) u_evt (
        .clk_i (clk_i),
        .rst_i (rst_all),
        .set_i ({cls_done_i, det_done_i}),
        .clr_i (evt_clr),
        .q_o   (evt_q)
    );

    esr_flag_bits #(.W(NPORT)) u_flt (
        .clk_i (clk_i),
        .rst_i (rst_all),
        .set_i (fault_i),
        .clr_i (flt_clr),
        .q_o   (flt_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        esr_port_status u_stat (
            .clk_i      (clk_i),
            .rst_i      (rst_all),
            .clr_i      (port_clr[p]),
            .det_done_i (det_done_i[p]),
            .det_code_i (det_code_i[p*CODE_W +: CODE_W]),
            .cls_done_i (cls_done_i[p]),
            .cls_code_i (cls_code_i[p*CODE_W +: CODE_W]),
            .res_o      (res[p])
        );
    end

    always_comb begin
        rmux = '0;
        if (addr_i == A_EVT || addr_i == A_EVT_COR) rmux = evt_q;
        if (addr_i == A_FAULT) rmux = DATA_W'(flt_q);
        for (int p = 0; p < NPORT; p++)
            if (addr_i == ADDR_W'(int'(A_STAT0) + p)) rmux = fmt_status(res[p]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_all)      rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rmux;
    end

    assign rdata_o = rdata_q;
    assign int_n_o = ~|flt_q;

    // R9: a fault pulse pulls the interrupt low on the next cycle
    p_fault_int_r9: assert property (@(posedge clk_i) disable iff (rst_all)
        (|fault_i) |=> !int_n_o);
    // R10: control address reads back as zero
    p_ctl_reads_zero_r10: assert property (@(posedge clk_i) disable iff (rst_all)
        (rd_en_i && addr_i == A_CTL) |=> rdata_o == '0);
    // R6: a port-off command only follows a write of that bit
    p_port_off_src_r6: assert property (@(posedge clk_i) disable iff (rst_all)
        (|port_off_o) |-> $past(wr_ctl));
    // R2: plain read leaves flags unchanged when nothing else acts
    p_plain_read_r2: assert property (@(posedge clk_i) disable iff (rst_all)
        (rd_en_i && addr_i == A_EVT && !(|det_done_i) && !(|cls_done_i)
         && !(|port_clr)) |=> $stable(evt_q));
    // R8: software reset empties the fault latch
    p_srst_clears_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        srst_q |=> (flt_q == '0 && evt_q == '0));
endmodule

// File: tb/test_esr_bank.sv
module test_esr_bank;
    logic       clk = 0;
    logic       rst;
    logic       rd_en, wr_en;
    logic [2:0] addr;
    logic [7:0] wdata, rdata;
    logic [3:0] det_done, cls_done, pwr_dn, fault, port_off;
    logic [11:0] det_code, cls_code;
    logic       int_n;
    int         n_run = 0, n_fail = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    esr_bank i_esr_bank (
        .clk_i(clk), .rst_i(rst), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .det_done_i(det_done), .det_code_i(det_code),
        .cls_done_i(cls_done), .cls_code_i(cls_code),
        .pwr_dn_i(pwr_dn), .fault_i(fault),
        .port_off_o(port_off), .int_n_o(int_n)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; v = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic det_pulse(input int p, input logic [2:0] c);
        @(negedge clk); det_done[p] = 1; det_code[p*3 +: 3] = c;
        @(negedge clk); det_done = 0;
    endtask

    task automatic cls_pulse(input int p, input logic [2:0] c);
        @(negedge clk); cls_done[p] = 1; cls_code[p*3 +: 3] = c;
        @(negedge clk); cls_done = 0;
    endtask

    task automatic hw_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic t_reset();
        hw_reset();
        rd(3'd0, rv); check("R1 reset event", rv, 8'h00);
        check("R9 reset int_n", {7'd0, int_n}, 8'h01);
        check("R6 reset port_off", {4'd0, port_off}, 8'h00);
    endtask

    task automatic t_flags_plain();
        det_pulse(0, 3'd5);
        cls_pulse(2, 3'd3);
        rd(3'd0, rv); check("R1 event bits", rv, 8'h41);
        rd(3'd0, rv); check("R2 plain read keeps", rv, 8'h41);
        rd(3'd2, rv); check("R4 status port0", rv, 8'h05);
        rd(3'd4, rv); check("R4 status port2", rv, 8'h30);
    endtask

    task automatic t_cor();
        rd(3'd1, rv); check("R3 cor returns", rv, 8'h41);
        rd(3'd0, rv); check("R3 cor cleared", rv, 8'h00);
        rd(3'd2, rv); check("R3 status kept", rv, 8'h05);
    endtask

    task automatic t_collision();
        cls_pulse(0, 3'd1);
        @(negedge clk); rd_en = 1; addr = 3'd1; det_done[1] = 1; det_code[5:3] = 3'd6;
        @(negedge clk); rd_en = 0; det_done = 0; rv = rdata;
        check("R5 cor old value", rv, 8'h10);
        rd(3'd0, rv); check("R5 pulse survives cor", rv, 8'h02);
        rd(3'd3, rv); check("R5 code loaded", rv, 8'h06);
        // pulse against power-down of the same port
        @(negedge clk); pwr_dn[1] = 1; cls_done[1] = 1; cls_code[5:3] = 3'd2;
        @(negedge clk); pwr_dn = 0; cls_done = 0;
        rd(3'd0, rv); check("R5 pulse survives pwr_dn", rv, 8'h20);
        rd(3'd3, rv); check("R5/R7 det cleared cls loaded", rv, 8'h20);
        rd(3'd1, rv);
    endtask

    task automatic fill_all();
        for (int p = 0; p < 4; p++) begin
            det_pulse(p, 3'(p + 1));
            cls_pulse(p, 3'(p + 4));
        end
    endtask

    task automatic t_port_reset();
        fill_all();
        @(negedge clk); fault[3] = 1;
        @(negedge clk); fault = 0;
        wr(3'd7, 8'h04);
        check("R6 port_off pulse", {4'd0, port_off}, 8'h04);
        @(negedge clk);
        check("R6 port_off self-clear", {4'd0, port_off}, 8'h00);
        rd(3'd0, rv); check("R6 only port2 flags", rv, 8'hBB);
        rd(3'd4, rv); check("R6 port2 status", rv, 8'h00);
        rd(3'd3, rv); check("R6 port1 status kept", rv, 8'h52);
        rd(3'd6, rv); check("R6 fault kept", rv, 8'h08);
        rd(3'd7, rv); check("R10 ctl reads 0", rv, 8'h00);
    endtask

    task automatic t_pwr_dn();
        @(negedge clk); pwr_dn[0] = 1;
        @(negedge clk); pwr_dn = 0;
        rd(3'd0, rv); check("R7 pwr_dn flags", rv, 8'hAA);
        rd(3'd2, rv); check("R7 pwr_dn status", rv, 8'h00);
        rd(3'd5, rv); check("R7 port3 kept", rv, 8'h74);
    endtask

    task automatic t_fault();
        check("R9 int low", {7'd0, int_n}, 8'h00);
        @(negedge clk); fault[1] = 1;
        @(negedge clk); fault = 0;
        rd(3'd6, rv); check("R9 fault bits", rv, 8'h0A);
        wr(3'd6, 8'h08);
        rd(3'd6, rv); check("R9 w1c one bit", rv, 8'h02);
        check("R9 int still low", {7'd0, int_n}, 8'h00);
        wr(3'd6, 8'h02);
        check("R9 int released", {7'd0, int_n}, 8'h01);
        @(negedge clk); fault[0] = 1;
        @(negedge clk); fault = 0;
        hw_reset();
        check("R9 hw reset releases", {7'd0, int_n}, 8'h01);
    endtask

    task automatic t_srst();
        fill_all();
        @(negedge clk); fault[2] = 1;
        @(negedge clk); fault = 0;
        wr(3'd7, 8'h10);
        @(negedge clk);
        rd(3'd0, rv); check("R8 srst events", rv, 8'h00);
        rd(3'd5, rv); check("R8 srst status", rv, 8'h00);
        rd(3'd6, rv); check("R8 srst faults", rv, 8'h00);
        check("R8 srst int", {7'd0, int_n}, 8'h01);
        rd(3'd7, rv); check("R10 after srst", rv, 8'h00);
    endtask

    initial begin
        rst = 1; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
        det_done = 0; cls_done = 0; pwr_dn = 0; fault = 0;
        det_code = 0; cls_code = 0;
        t_reset();
        t_flags_plain();
        t_cor();
        t_collision();
        t_port_reset();
        t_pwr_dn();
        t_fault();
        t_srst();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule